// File: doc/BRIEF.md
# Interleaved Memory Block-Refill Controller

This block fills one cache line from a main memory split into four word-interleaved banks. A requester presents a block address. The controller opens that block in the banks, waits out the access latency and returns the line's words with valid, last and done indications. Word `k` of a block lives in bank `k`, at the row given by the upper address bits.

The memory organization is chosen at build time with the `ORG` parameter. In the simple organization every word pays its own address, access and transfer phase, on a one-word path. In the wide organization the bank path is a whole line wide, so one address phase and one access deliver the complete line in a single beat. In the interleaved organization one address phase starts all four banks together. After the shared access the words come back on consecutive cycles over a one-word path.

The banks are behavioural register arrays inside the block. A preload write port fills them while the controller is idle.

Top module: `memrefill_ctrl`

## Requirements
- R1: After reset `busy_o`, `rsp_valid_o` and `done_o` are low.
- R2: A preload write (`wr_en_i` high while idle) stores `wr_data_i` at word address `wr_addr_i`. The bank is `wr_addr_i[1:0]` and the row is `wr_addr_i[5:2]`.
- R3: Interleaved (`ORG`=2). The cycle in which the request is taken is cycle 1. Words 0, 1, 2 and 3 are valid in cycles 8, 9, 10 and 11, so the last word arrives 11 cycles after the request.
- R4: Simple (`ORG`=0). Word `k` is valid only in cycle 8·(k+1), so the last word arrives in cycle 32, and `rsp_valid_o` is low in every other cycle.
- R5: Wide (`ORG`=1). A single beat in cycle 8 carries the whole line. Word `k` is on `rsp_data_o[32k+31:32k]`, with `rsp_idx_o`=0 and `rsp_last_o`=1.
- R6: The two low bits of `req_addr_i` are ignored, so the line is always the aligned 4-word block.
- R7: A request is taken only while `busy_o` is low. `busy_o` is high from cycle 2 through the last-word cycle and low the cycle after. A request made while busy is ignored and starts no later refill.
- R8: Preload writes made while `busy_o` is high are ignored and leave the banks unchanged.
- R9: `done_o` is a one-cycle pulse in exactly the cycle where `rsp_valid_o` and `rsp_last_o` are both high. `rsp_idx_o` gives the word index of each beat.
- R10: A beat for word `k` carries the word stored at the aligned block base plus `k`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Refill request |
| req_addr_i | input | AW | Word address inside the wanted block |
| wr_en_i | input | 1 | Preload write enable |
| wr_addr_i | input | AW | Preload word address |
| wr_data_i | input | W | Preload data |
| busy_o | output | 1 | Refill in progress |
| rsp_valid_o | output | 1 | Response beat valid |
| rsp_last_o | output | 1 | Final beat of the line |
| rsp_idx_o | output | log2(NB) | Word index of the beat |
| rsp_data_o | output | W or NB·W | Beat data (line wide when ORG=1) |
| done_o | output | 1 | Refill complete pulse |

## Verification
The bench builds three copies side by side with `ORG` set to 2, 0 and 1, all using W=32, AW=6, NB=4 and T_ACC=6. Every refill is therefore compared across the 11, 32 and 8 cycle schedules at once. Because the copies share stimulus, a request or write injected during a refill lands in the busy window of all three organizations. Random unaligned addresses and random rewrites reach every row and every bank.

// File: rtl/refill_pkg.sv
package refill_pkg;
  localparam int ORG_SIMPLE      = 0;
  localparam int ORG_WIDE        = 1;
  localparam int ORG_INTERLEAVED = 2;

  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_ACCESS, PH_XFER} phase_e;

  // number of response beats per line for an organization
  function automatic int beats_for(int org, int nb);
    return (org == ORG_WIDE) ? 1 : nb;
  endfunction

  // request-to-last-word cycles: 1 address, tacc access, 1 per transfer
  function automatic int penalty(int org, int nb, int tacc);
    case (org)
      ORG_SIMPLE: return nb * (1 + tacc + 1);
      ORG_WIDE:   return 1 + tacc + 1;
      default:    return 1 + tacc + nb;
    endcase
  endfunction
endpackage

// File: rtl/refill_bank.sv
module refill_bank #(
  parameter int W    = 32,
  parameter int ROWS = 16,
  localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [RW-1:0] wrow_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [RW-1:0] rrow_i,
  output logic [W-1:0]  q_o
);
  logic [W-1:0] mem_q [ROWS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wrow_i] <= wdata_i;
  end

  assign q_o = mem_q[rrow_i];
endmodule

// File: rtl/refill_seq.sv
module refill_seq
  import refill_pkg::*;
#(
  parameter int ORG   = ORG_INTERLEAVED,
  parameter int NB    = 4,
  parameter int T_ACC = 6,
  localparam int BW    = $clog2(NB),
  localparam int BEATS = beats_for(ORG, NB),
  localparam int CW    = (T_ACC > 1) ? $clog2(T_ACC) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic          beat_fire_o,
  output logic          last_fire_o,
  output logic [BW-1:0] beat_o
);
  phase_e        ph_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] beat_q;
  logic          final_beat_w;

  assign final_beat_w = (beat_q == BW'(BEATS - 1));

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      beat_q <= '0;
    end else begin
      case (ph_q)
        PH_IDLE: if (start_i) begin
          // the request cycle is the address phase
          ph_q   <= PH_ACCESS;
          cnt_q  <= CW'(T_ACC - 1);
          beat_q <= '0;
        end
        PH_ADDR: begin
          ph_q  <= PH_ACCESS;
          cnt_q <= CW'(T_ACC - 1);
        end
        PH_ACCESS: begin
          if (cnt_q == '0) ph_q <= PH_XFER;
          else             cnt_q <= cnt_q - 1'b1;
        end
        PH_XFER: begin
          if (final_beat_w) begin
            ph_q   <= PH_IDLE;
            beat_q <= '0;
          end else begin
            beat_q <= beat_q + 1'b1;
            ph_q   <= (ORG == ORG_SIMPLE) ? PH_ADDR : PH_XFER;
          end
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign busy_o      = (ph_q != PH_IDLE);
  assign beat_fire_o = (ph_q == PH_XFER);
  assign last_fire_o = beat_fire_o && final_beat_w;
  assign beat_o      = beat_q;
endmodule

// File: rtl/memrefill_ctrl.sv
module memrefill_ctrl
  import refill_pkg::*;
#(
  parameter int ORG   = ORG_INTERLEAVED,
  parameter int W     = 32,
  parameter int AW    = 6,
  parameter int NB    = 4,
  parameter int T_ACC = 6,
  localparam int BW    = $clog2(NB),
  localparam int ROWS  = (1 << AW) / NB,
  localparam int RW    = AW - BW,
  localparam int LANES = (ORG == ORG_WIDE) ? NB : 1,
  localparam int BUS_W = LANES * W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic             wr_en_i,
  input  logic [AW-1:0]    wr_addr_i,
  input  logic [W-1:0]     wr_data_i,
  output logic             busy_o,
  output logic             rsp_valid_o,
  output logic             rsp_last_o,
  output logic [BW-1:0]    rsp_idx_o,
  output logic [BUS_W-1:0] rsp_data_o,
  output logic             done_o
);
  // named internal events
  logic          accept_w;
  logic          wr_ok_w;
  logic          beat_fire_w;
  logic          last_fire_w;
  logic [BW-1:0] beat_w;
  logic [RW-1:0] row_q;
  logic          unused_lo;
  logic [W-1:0]  bank_q [NB];

  assign accept_w  = req_i && !busy_o;
  assign wr_ok_w   = wr_en_i && !busy_o;
  // block alignment: the bank-select bits of the request are dropped
  assign unused_lo = ^req_addr_i[BW-1:0];

  always_ff @(posedge clk_i) begin
    if (!rst_ni)       row_q <= '0;
    else if (accept_w) row_q <= req_addr_i[AW-1:BW];
  end

  refill_seq #(.ORG(ORG), .NB(NB), .T_ACC(T_ACC)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (accept_w),
    .busy_o      (busy_o),
    .beat_fire_o (beat_fire_w),
    .last_fire_o (last_fire_w),
    .beat_o      (beat_w)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    refill_bank #(.W(W), .ROWS(ROWS)) u_bank (
      .clk_i   (clk_i),
      .we_i    (wr_ok_w && (wr_addr_i[BW-1:0] == BW'(b))),
      .wrow_i  (wr_addr_i[AW-1:BW]),
      .wdata_i (wr_data_i),
      .rrow_i  (row_q),
      .q_o     (bank_q[b])
    );
  end

  if (ORG == ORG_WIDE) begin : g_wide
    for (genvar b = 0; b < NB; b++) begin : g_lane
      assign rsp_data_o[b*W +: W] = bank_q[b];
    end
    assign rsp_last_o = beat_fire_w;
  end else begin : g_narrow
    assign rsp_data_o = bank_q[beat_w];
    assign rsp_last_o = beat_fire_w && (beat_w == BW'(NB - 1));
  end

  assign rsp_valid_o = beat_fire_w;
  assign rsp_idx_o   = beat_w;
  assign done_o      = last_fire_w;
endmodule

// File: rtl/refill_chk.sv
module refill_chk
  import refill_pkg::*;
#(
  parameter int ORG   = ORG_INTERLEAVED,
  parameter int NB    = 4,
  parameter int T_ACC = 6,
  parameter int BW    = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          busy_o,
  input logic          rsp_valid_o,
  input logic          rsp_last_o,
  input logic          done_o,
  input logic [BW-1:0] rsp_idx_o
);
  localparam int PEN = penalty(ORG, NB, T_ACC);

  logic [15:0] cyc_q;
  logic        unused_idx;
  assign unused_idx = ^rsp_idx_o;

  always_ff @(posedge clk_i) begin
    if (!rst_ni)               cyc_q <= '0;
    else if (req_i && !busy_o) cyc_q <= 16'd1;
    else if (busy_o)           cyc_q <= cyc_q + 16'd1;
  end

  // R9
  done_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o == (rsp_valid_o && rsp_last_o));

  // R9
  valid_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> busy_o);

  // R7
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o) |=> busy_o);

  // R7
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

  // R3 R4 R5
  penalty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cyc_q == 16'(PEN - 1)));

  if (ORG == ORG_INTERLEAVED) begin : g_il
    // R3
    stream_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rsp_valid_o && !rsp_last_o) |=>
        (rsp_valid_o && rsp_idx_o == BW'($past(rsp_idx_o) + 1'b1)));
  end else if (ORG == ORG_SIMPLE) begin : g_sp
    // R4
    gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rsp_valid_o && !rsp_last_o) |=> !rsp_valid_o);
  end else begin : g_wd
    // R5
    single_beat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_valid_o |-> (rsp_last_o && rsp_idx_o == '0));
  end
endmodule

bind memrefill_ctrl refill_chk #(.ORG(ORG), .NB(NB), .T_ACC(T_ACC), .BW(BW)) u_chk (.*);

// File: tb/sim_memrefill_ctrl.sv
`timescale 1ns/1ps
module sim_memrefill_ctrl;
  localparam int W = 32, AW = 6, NB = 4, TACC = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] req_addr = '0, wr_addr = '0;
  logic [W-1:0]  wr_data = '0;

  logic busy [3], valid [3], last [3], done [3];
  logic [1:0]    idx [3];
  logic [W-1:0]  d0, d1;
  logic [4*W-1:0] d2;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [W-1:0] shm [64];

  always #2 clk = ~clk;

  memrefill_ctrl #(.ORG(2)) u0 (.clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_addr_i(req_addr),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .busy_o(busy[0]),
    .rsp_valid_o(valid[0]), .rsp_last_o(last[0]), .rsp_idx_o(idx[0]), .rsp_data_o(d0), .done_o(done[0]));
  memrefill_ctrl #(.ORG(0)) u1 (.clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_addr_i(req_addr),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .busy_o(busy[1]),
    .rsp_valid_o(valid[1]), .rsp_last_o(last[1]), .rsp_idx_o(idx[1]), .rsp_data_o(d1), .done_o(done[1]));
  memrefill_ctrl #(.ORG(1)) u2 (.clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_addr_i(req_addr),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data), .busy_o(busy[2]),
    .rsp_valid_o(valid[2]), .rsp_last_o(last[2]), .rsp_idx_o(idx[2]), .rsp_data_o(d2), .done_o(done[2]));

  // instance 0 interleaved, 1 simple, 2 wide
  function automatic int org_of(int i);
    return (i == 0) ? 2 : (i == 1) ? 0 : 1;
  endfunction

  function automatic int pen_of(int org);
    return (org == 0) ? 32 : (org == 1) ? 8 : 11;
  endfunction

  // word index delivered in cycle c, or -1
  function automatic int exp_beat(int org, int c);
    if (org == 1) return (c == 8) ? 0 : -1;
    if (org == 0) return (c % 8 == 0 && c >= 8 && c <= 32) ? c / 8 - 1 : -1;
    return (c >= 8 && c <= 11) ? c - 8 : -1;
  endfunction

  function automatic string ttag(int i);
    return (i == 0) ? "R3" : (i == 1) ? "R4" : "R5";
  endfunction

  task automatic chk(bit ok, string rq, string what, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic wr(int a, logic [W-1:0] d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    shm[a] = d;
  endtask

  // issues a refill at the current negedge and checks cycles 2..36
  task automatic refill(int addr, bit inject, string dtag);
    int base;
    logic [W-1:0] ew [4];
    base = addr & 'h3C;
    for (int k = 0; k < 4; k++) ew[k] = shm[base + k];
    req = 1'b1; req_addr = AW'(addr);
    for (int c = 2; c <= 36; c++) begin
      @(negedge clk);
      for (int i = 0; i < 3; i++) begin
        int o, p, eb;
        logic [W-1:0] dn;
        o = org_of(i); p = pen_of(o); eb = exp_beat(o, c);
        chk(busy[i] == (c <= p), "R7", $sformatf("busy u%0d cyc %0d", i, c), 128'(busy[i]), 128'(c <= p));
        chk(valid[i] == (eb >= 0), ttag(i), $sformatf("valid u%0d cyc %0d", i, c), 128'(valid[i]), 128'(eb >= 0));
        chk(done[i] == (c == p), "R9", $sformatf("done u%0d cyc %0d", i, c), 128'(done[i]), 128'(c == p));
        if (eb >= 0 && valid[i]) begin
          chk(idx[i] == 2'(eb), "R9", $sformatf("idx u%0d", i), 128'(idx[i]), 128'(eb));
          chk(last[i] == (o == 1 || eb == 3), "R9", $sformatf("last u%0d", i), 128'(last[i]), 128'(o == 1 || eb == 3));
          if (i == 2) begin
            chk(d2 == {ew[3], ew[2], ew[1], ew[0]}, "R5", $sformatf("line %s", dtag), d2,
                {ew[3], ew[2], ew[1], ew[0]});
          end else begin
            dn = (i == 0) ? d0 : d1;
            chk(dn == ew[eb], "R10", $sformatf("word %0d u%0d %s", eb, i, dtag), 128'(dn), 128'(ew[eb]));
          end
        end
      end
      if (c == 2) req = 1'b0;
      if (inject && c == 3) begin
        // R7 R8: request and write while all copies are busy
        req = 1'b1; req_addr = AW'(addr ^ 'h10);
        wr_en = 1'b1; wr_addr = AW'(base + 1); wr_data = ~ew[1];
      end
      if (c == 4) begin req = 1'b0; wr_en = 1'b0; end
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    // R1 reset state
    for (int i = 0; i < 3; i++) begin
      chk(!busy[i], "R1", "busy", 128'(busy[i]), 0);
      chk(!valid[i], "R1", "valid", 128'(valid[i]), 0);
      chk(!done[i], "R1", "done", 128'(done[i]), 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    // R2 preload every word
    for (int a = 0; a < 64; a++) wr(a, $urandom());
    refill(0, 0, "R2");
    refill('h3F, 0, "R6");        // R6 unaligned, low bits 11
    refill('h15, 1, "R7");        // ignored request and write while busy
    refill('h14, 0, "R8");        // block unchanged by the ignored write
    for (int n = 0; n < 20; n++) begin
      wr($urandom_range(63), $urandom());   // R2 rewrite
      refill($urandom_range(63), n[0], "R10");
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule